// File: doc/BRIEF.md
# Integer ALU with Status Flags

This block is a signed integer arithmetic and logic unit with a configurable operand width (default 32 bits, up to 256). Each operation is issued by pulsing `start` with an operation code, two operands and a shift count. Most operations produce their result in one cycle. Multiply and divide run iteratively, one bit per cycle, and hold `busy_o` high while they run. `done_o` pulses for one cycle when the result and the status byte are updated.

The 8-bit status byte has a fixed layout that other logic decodes. Bit 0 flags a zero result. Bit 1 flags signed overflow. Bit 2 flags a divide with a zero divisor. Bits 3 to 5 form a one-hot compare outcome that only the compare operation writes. Bits 6 and 7 always read as zero. The shift count is taken modulo the operand width.

Top module: `alu_flags_core`

## Requirements
- R1: ADD (opcode 0) returns A+B and SUB (opcode 1) returns A-B, both modulo 2^W; status bit 1 is set on two's-complement signed overflow and cleared otherwise.
- R2: AND (4), OR (5) and XOR (6) return the bitwise combination of A and B; NOT (7) returns the complement of A; all four clear status bit 1.
- R3: SHL (8) shifts A left and SHR (9) shifts A right, both logical; ROR (10) rotates A right; the count is the shift input modulo W.
- R4: Every operation that writes the result sets status bit 0 exactly when the new result is zero, and clears status bit 2 unless it is a divide by zero.
- R5: CMP (11) compares A and B as signed values and sets exactly one of bit 3 (A<B), bit 4 (A=B) or bit 5 (A>B); it sets bit 0 on equality and leaves the result, bit 1 and bit 2 unchanged.
- R6: No operation other than CMP changes status bits 3 to 5; status bits 7:6 are always 00.
- R7: MUL (2) returns the low W bits of the signed product and sets bit 1 when the upper W bits are not the sign extension of the low half; `done_o` rises W cycles after the edge that accepted `start`.
- R8: DIV (3) with a nonzero divisor returns the signed quotient truncated toward zero after W cycles; the most negative value divided by -1 returns the most negative value with bit 1 set.
- R9: DIV with a zero divisor completes in the accepting cycle, returns 0 and sets bits 2 and 0 with bit 1 cleared.
- R10: Single-cycle operations raise `done_o` in the cycle after `start`; `start` is ignored while `busy_o` is high; a new `start` is accepted in the cycle that `done_o` is high.
- R11: After reset the result is 0, the status is 0, and `done_o` and `busy_o` are low.
- R12: Opcodes 12 to 15 pulse `done_o` and change neither the result nor the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Issue an operation this cycle |
| op_i | input | 4 | Operation code |
| opa_i | input | W | First operand (the shifted operand) |
| opb_i | input | W | Second operand |
| shamt_i | input | SHW | Shift or rotate count |
| result_o | output | W | Last result |
| status_o | output | 8 | Status byte |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Multiply or divide in progress |

## Verification
Two events can fall in the same cycle: the completion of an iterative multiply or divide, and the acceptance of the next operation. Two further events also coincide: a `start` presented while busy and the last step of that iteration. The bench issues every operation at the negedge where it sees `done_o`, so each new operation is accepted in a completion cycle. It also holds `start` high with an ADD on every busy cycle of a multiply. It then judges the outcome by checking that the multiply result, its flags and its latency match the reference model. It also checks that no extra `done_o` follows and that the result stays unchanged.

// File: rtl/alu_flags_pkg.sv
`timescale 1ns/1ps
package alu_flags_pkg;

    localparam logic [3:0] OP_ADD = 4'd0;
    localparam logic [3:0] OP_SUB = 4'd1;
    localparam logic [3:0] OP_MUL = 4'd2;
    localparam logic [3:0] OP_DIV = 4'd3;
    localparam logic [3:0] OP_AND = 4'd4;
    localparam logic [3:0] OP_OR  = 4'd5;
    localparam logic [3:0] OP_XOR = 4'd6;
    localparam logic [3:0] OP_NOT = 4'd7;
    localparam logic [3:0] OP_SHL = 4'd8;
    localparam logic [3:0] OP_SHR = 4'd9;
    localparam logic [3:0] OP_ROR = 4'd10;
    localparam logic [3:0] OP_CMP = 4'd11;

    // Status byte, MSB first: bit0 zero, bit1 overflow, bit2 divide-by-zero,
    // bits 3..5 compare less/equal/greater, bits 6..7 always zero.
    typedef struct packed {
        logic [1:0] rsv;
        logic       gt;
        logic       eq;
        logic       lt;
        logic       dz;
        logic       ov;
        logic       zf;
    } stat_t;

    // Single-cycle operations other than compare.
    function automatic logic is_single(input logic [3:0] op);
        return (op <= OP_ROR) && (op != OP_MUL) && (op != OP_DIV);
    endfunction

    function automatic stat_t stat_after_result(input stat_t prev, input logic z,
                                                input logic ov, input logic dz);
        stat_t s;
        s     = prev;
        s.zf  = z;
        s.ov  = ov;
        s.dz  = dz;
        s.rsv = 2'b00;
        return s;
    endfunction

    function automatic stat_t stat_after_cmp(input stat_t prev, input logic lt,
                                             input logic eq, input logic gt);
        stat_t s;
        s     = prev;
        s.lt  = lt;
        s.eq  = eq;
        s.gt  = gt;
        s.zf  = eq;
        s.rsv = 2'b00;
        return s;
    endfunction

endpackage

// File: rtl/alu_single_unit.sv
`timescale 1ns/1ps
module alu_single_unit
    import alu_flags_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 8
) (
    input  logic [3:0]     op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SHW-1:0] shamt,
    output logic [W-1:0]   res,
    output logic           ovf,
    output logic           lt,
    output logic           eq,
    output logic           gt
);
    logic [W-1:0]   sum;
    logic [W-1:0]   dif;
    logic [2*W-1:0] dbl;
    int unsigned    k;

    assign sum = a + b;
    assign dif = a - b;
    assign lt  = $signed(a) < $signed(b);
    assign eq  = (a == b);
    assign gt  = !lt && !eq;

    always_comb begin
        k   = 32'(shamt) % W;
        dbl = {a, a} >> k;
        res = '0;
        ovf = 1'b0;
        case (op)
            OP_ADD: begin
                res = sum;
                ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
            end
            OP_SUB: begin
                res = dif;
                ovf = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
            end
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_NOT: res = ~a;
            OP_SHL: res = a << k;
            OP_SHR: res = a >> k;
            OP_ROR: res = dbl[W-1:0];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_mul_iter.sv
`timescale 1ns/1ps
module alu_mul_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         last,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int CW = $clog2(W) + 1;

    logic [W-1:0]   hi_q, lo_q, mc_q;
    logic           neg_q, run_q;
    logic [CW-1:0]  cnt_q;
    logic [W:0]     sum;
    logic [W-1:0]   hi_n, lo_n;
    logic [2*W-1:0] mag, prod;

    function automatic logic [W-1:0] absval(input logic [W-1:0] v);
        return v[W-1] ? (~v + 1'b1) : v;
    endfunction

    assign sum  = {1'b0, hi_q} + ({1'b0, mc_q} & {(W+1){lo_q[0]}});
    assign hi_n = sum[W:1];
    assign lo_n = {sum[0], lo_q[W-1:1]};
    assign mag  = {hi_n, lo_n};
    assign prod = neg_q ? (~mag + 1'b1) : mag;
    assign res  = prod[W-1:0];
    assign ovf  = prod[2*W-1:W] != {W{prod[W-1]}};
    assign last = run_q && (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            lo_q  <= '0;
            mc_q  <= '0;
            neg_q <= 1'b0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (go) begin
            hi_q  <= '0;
            lo_q  <= absval(b);
            mc_q  <= absval(a);
            neg_q <= a[W-1] ^ b[W-1];
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            cnt_q <= cnt_q + 1'b1;
            if (last) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/alu_div_iter.sv
`timescale 1ns/1ps
module alu_div_iter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         last,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int CW = $clog2(W) + 1;

    logic [W:0]    rem_q;
    logic [W-1:0]  q_q, d_q;
    logic          neg_q, run_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shl, trial, rem_n;
    logic          fits;
    logic [W-1:0]  q_n;

    function automatic logic [W-1:0] absval(input logic [W-1:0] v);
        return v[W-1] ? (~v + 1'b1) : v;
    endfunction

    assign shl   = {rem_q[W-1:0], q_q[W-1]};
    assign trial = shl - {1'b0, d_q};
    assign fits  = !trial[W];
    assign rem_n = fits ? trial : shl;
    assign q_n   = {q_q[W-2:0], fits};
    assign res   = neg_q ? (~q_n + 1'b1) : q_n;
    assign ovf   = !neg_q && q_n[W-1];
    assign last  = run_q && (cnt_q == CW'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            q_q   <= '0;
            d_q   <= '0;
            neg_q <= 1'b0;
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (go) begin
            rem_q <= '0;
            q_q   <= absval(a);
            d_q   <= absval(b);
            neg_q <= a[W-1] ^ b[W-1];
            run_q <= 1'b1;
            cnt_q <= '0;
        end else if (run_q) begin
            rem_q <= rem_n;
            q_q   <= q_n;
            cnt_q <= cnt_q + 1'b1;
            if (last) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/alu_flags_core.sv
`timescale 1ns/1ps
module alu_flags_core
    import alu_flags_pkg::*;
#(
    parameter int W   = 32,
    parameter int SHW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opa_i,
    input  logic [W-1:0]   opb_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   result_o,
    output logic [7:0]     status_o,
    output logic           done_o,
    output logic           busy_o
);
    logic [W-1:0] result_q;
    stat_t        stat_q;
    logic         done_q, busy_q;

    logic         accept, mul_go, div_go, div_zero;
    logic [W-1:0] su_res, mul_res, div_res;
    logic         su_ovf, su_lt, su_eq, su_gt;
    logic         mul_last, mul_ovf, div_last, div_ovf;

    assign accept   = start && !busy_q;
    assign div_zero = (opb_i == '0);
    assign mul_go   = accept && (op_i == OP_MUL);
    assign div_go   = accept && (op_i == OP_DIV) && !div_zero;

    alu_single_unit #(.W(W), .SHW(SHW)) u_single (
        .op(op_i), .a(opa_i), .b(opb_i), .shamt(shamt_i),
        .res(su_res), .ovf(su_ovf), .lt(su_lt), .eq(su_eq), .gt(su_gt)
    );

    alu_mul_iter #(.W(W)) u_mul (
        .clk(clk), .rst(rst), .go(mul_go), .a(opa_i), .b(opb_i),
        .last(mul_last), .res(mul_res), .ovf(mul_ovf)
    );

    alu_div_iter #(.W(W)) u_div (
        .clk(clk), .rst(rst), .go(div_go), .a(opa_i), .b(opb_i),
        .last(div_last), .res(div_res), .ovf(div_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            stat_q   <= '0;
            done_q   <= 1'b0;
            busy_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (mul_last) begin
                result_q <= mul_res;
                stat_q   <= stat_after_result(stat_q, mul_res == '0, mul_ovf, 1'b0);
                done_q   <= 1'b1;
                busy_q   <= 1'b0;
            end else if (div_last) begin
                result_q <= div_res;
                stat_q   <= stat_after_result(stat_q, div_res == '0, div_ovf, 1'b0);
                done_q   <= 1'b1;
                busy_q   <= 1'b0;
            end else if (accept) begin
                if (mul_go || div_go) begin
                    busy_q <= 1'b1;
                end else if (op_i == OP_DIV) begin
                    result_q <= '0;
                    stat_q   <= stat_after_result(stat_q, 1'b1, 1'b0, 1'b1);
                    done_q   <= 1'b1;
                end else if (op_i == OP_CMP) begin
                    stat_q <= stat_after_cmp(stat_q, su_lt, su_eq, su_gt);
                    done_q <= 1'b1;
                end else if (is_single(op_i)) begin
                    result_q <= su_res;
                    stat_q   <= stat_after_result(stat_q, su_res == '0, su_ovf, 1'b0);
                    done_q   <= 1'b1;
                end else begin
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign result_o = result_q;
    assign status_o = stat_q;
    assign done_o   = done_q;
    assign busy_o   = busy_q;
endmodule

// File: rtl/alu_flags_chk.sv
`timescale 1ns/1ps
module alu_flags_chk
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [3:0]   op_i,
    input logic [W-1:0] opb_i,
    input logic [W-1:0] result_o,
    input logic [7:0]   status_o,
    input logic         done_o,
    input logic         busy_o
);
    logic acc;
    assign acc = start && !busy_o;

    p_rsv_zero_r6: assert property (@(posedge clk) disable iff (rst)
        status_o[7:6] == 2'b00);

    p_cr_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(status_o[5:3]));

    p_cr_only_cmp_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(status_o[5:3]) |-> $past(acc && op_i == OP_CMP));

    p_cmp_keeps_result_r5: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == OP_CMP) |=> (done_o && $stable(result_o)));

    p_div_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == OP_DIV && opb_i == '0) |=>
            (done_o && status_o[2] && status_o[0] && !status_o[1] && result_o == '0));

    p_busy_no_done_r10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o);

    p_single_done_r10: assert property (@(posedge clk) disable iff (rst)
        (acc && is_single(op_i)) |=> (done_o && !busy_o));

    p_mul_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == OP_MUL) |=> (busy_o && !done_o));
endmodule

bind alu_flags_core alu_flags_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .op_i(op_i), .opb_i(opb_i),
    .result_o(result_o), .status_o(status_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/tb_alu_flags_core.sv
`timescale 1ns/1ps
module tb_alu_flags_core;
    localparam int W   = 32;
    localparam int SHW = 8;
    localparam logic [31:0] MINV = 32'h8000_0000;
    localparam logic [31:0] MAXV = 32'h7fff_ffff;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [3:0]     op_i = '0;
    logic [W-1:0]   opa_i = '0, opb_i = '0;
    logic [SHW-1:0] shamt_i = '0;
    logic [W-1:0]   result_o;
    logic [7:0]     status_o;
    logic           done_o, busy_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] m_res  = '0;
    logic [7:0]  m_stat = '0;

    always #4 clk = ~clk;

    alu_flags_core #(.W(W), .SHW(SHW)) dut (
        .clk(clk), .rst(rst), .start(start), .op_i(op_i), .opa_i(opa_i),
        .opb_i(opb_i), .shamt_i(shamt_i), .result_o(result_o),
        .status_o(status_o), .done_o(done_o), .busy_o(busy_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op, input logic [31:0] b);
        case (op)
            4'd0, 4'd1:             return "R1";
            4'd4, 4'd5, 4'd6, 4'd7: return "R2";
            4'd8, 4'd9, 4'd10:      return "R3";
            4'd11:                  return "R5";
            4'd2:                   return "R7";
            4'd3:                   return (b == 0) ? "R9" : "R8";
            default:                return "R12";
        endcase
    endfunction

    // Reference model from the requirements; updates model state.
    task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [7:0] sh, output logic [31:0] er,
                         output logic [7:0] es, output int lat);
        logic [31:0] r;
        logic        ov, dz;
        longint      p, q;
        int          k;
        bit          wr;
        r = m_res; ov = 1'b0; dz = 1'b0; wr = 1'b1; lat = 0;
        k = int'(sh) % W;
        es = m_stat;
        case (op)
            4'd0: begin r = a + b; ov = (a[31] == b[31]) && (r[31] != a[31]); end
            4'd1: begin r = a - b; ov = (a[31] != b[31]) && (r[31] != a[31]); end
            4'd2: begin
                p = longint'($signed(a)) * longint'($signed(b));
                r = p[31:0];
                ov = p[63:32] != {32{r[31]}};
                lat = W;
            end
            4'd3: begin
                if (b == 0) begin r = '0; dz = 1'b1; end
                else begin
                    q = longint'($signed(a)) / longint'($signed(b));
                    r = q[31:0];
                    ov = q > 64'sd2147483647;
                    lat = W;
                end
            end
            4'd4: r = a & b;
            4'd5: r = a | b;
            4'd6: r = a ^ b;
            4'd7: r = ~a;
            4'd8: r = a << k;
            4'd9: r = a >> k;
            4'd10: r = (k == 0) ? a : ((a >> k) | (a << (W - k)));
            4'd11: begin
                wr = 1'b0;
                es[3] = $signed(a) < $signed(b);
                es[4] = a == b;
                es[5] = $signed(a) > $signed(b);
                es[0] = a == b;
            end
            default: wr = 1'b0;
        endcase
        if (wr) es = {2'b00, m_stat[5:3], dz, ov, r == 0};
        er = r;
        m_res = er;
        m_stat = es;
    endtask

    // Drive at a negedge, return at the negedge where done is seen.
    task automatic run_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic [7:0] sh, input bit spam);
        logic [31:0] er;
        logic [7:0]  es;
        int lat, n;
        string t;
        t = tag_of(op, b);
        model(op, a, b, sh, er, es, lat);
        op_i = op; opa_i = a; opb_i = b; shamt_i = sh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done_o && n < 1000) begin
            if (spam) begin
                start = 1'b1; op_i = 4'd0; opa_i = 32'd5; opb_i = 32'd6;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(result_o == er, t, "result", 64'(result_o), 64'(er));
        chk(status_o == es, {t, " R4 R6"}, "status", 64'(status_o), 64'(es));
        chk(n == lat, {t, " R10"}, "latency", 64'(n), 64'(lat));
        if (spam) begin
            @(negedge clk);
            chk(!done_o && result_o == er, "R10", "busy start ignored",
                64'(result_o), 64'(er));
        end
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 8)
            0: return 32'd0;
            1: return MINV;
            2: return MAXV;
            3: return 32'hffff_ffff;
            4: return 32'd1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R10: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk(result_o == 0 && status_o == 0 && !done_o && !busy_o, "R11", "reset",
            {result_o, 22'd0, status_o, done_o, busy_o}, 64'd0);

        run_op(4'd12, 32'd1, 32'd2, 8'd0, 1'b0);           // R12 unused code
        run_op(4'd0, MAXV, 32'd1, 8'd0, 1'b0);             // R1 overflow
        run_op(4'd1, MINV, 32'd1, 8'd0, 1'b0);             // R1 overflow
        run_op(4'd1, 32'd5, 32'd7, 8'd0, 1'b0);            // R1 5-7
        run_op(4'd0, 32'hffff_ffff, 32'd1, 8'd0, 1'b0);    // R4 zero result
        run_op(4'd11, 32'hffff_ffff, 32'd1, 8'd0, 1'b0);   // R5 signed less
        run_op(4'd7, 32'h0f0f_0000, 32'd0, 8'd0, 1'b0);    // R2 not, R6 keeps field
        run_op(4'd11, 32'd9, 32'd9, 8'd0, 1'b0);           // R5 equal
        run_op(4'd11, 32'd1, MINV, 8'd0, 1'b0);            // R5 greater
        run_op(4'd8, 32'h8000_0003, 32'd0, 8'd33, 1'b0);   // R3 count modulo
        run_op(4'd10, 32'h0000_00f1, 32'd0, 8'd4, 1'b0);   // R3 rotate
        run_op(4'd9, MINV, 32'd0, 8'd31, 1'b0);            // R3 logical right
        run_op(4'd10, 32'h1234_5678, 32'd0, 8'd64, 1'b0);  // R3 rotate by width multiple
        run_op(4'd2, MINV, 32'hffff_ffff, 8'd0, 1'b0);     // R7 overflow
        run_op(4'd2, 32'hffff_fffd, 32'd7, 8'd0, 1'b0);    // R7 -3*7
        run_op(4'd3, 32'hffff_fff9, 32'd2, 8'd0, 1'b0);    // R8 -7/2 = -3
        run_op(4'd3, MINV, 32'hffff_ffff, 8'd0, 1'b0);     // R8 overflow
        run_op(4'd3, 32'd77, 32'd0, 8'd0, 1'b0);           // R9 zero divisor
        run_op(4'd11, 32'd3, 32'd3, 8'd0, 1'b0);
        run_op(4'd2, 32'd1234, 32'hffff_ff00, 8'd0, 1'b1); // R10 start while busy
        run_op(4'd3, 32'd1000, 32'd7, 8'd0, 1'b1);         // R10 start while busy

        for (int i = 0; i < 400; i++) begin
            run_op(4'($urandom % 16), pick(), pick(), 8'($urandom), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule